// File: doc/BRIEF.md
# Shadowed LCD Video Timing Generator

This block drives the raster timing of an RGB panel: horizontal sync, vertical sync and a data-enable strobe, all advanced by a pixel-rate enable that comes from an integer clock divider. Software sets up the line and frame geometry, the divider, the enables, the output polarities and a frame interrupt through a simple write port of address, data and strobe.

Every porch, sync width and active dimension is stored as its real count minus one. Geometry writes land in a pending copy. The live copy that the scan counters use is refreshed only at frame start, which is also when vsync asserts. A protect bit lets software hold off that refresh while it rewrites several fields, so the scan never runs on a half-updated configuration. A sticky frame interrupt can be raised at frame start or at the start of the vertical front porch, and is cleared by writing a one.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, hsync_o, vsync_o, de_o and irq_o are all low and no scan runs.
- R2: Scanning runs only while both the immediate run bit (CTRL address 0, bit 0) and the frame run bit (CTRL bit 1) are set; with either one alone, all outputs stay inactive.
- R3: Each line is made of hsync (HTIME address 1, bits 23:16, plus one pixels), then back porch (HTIME bits 7:0 plus one), then active width (SIZE address 3, bits 10:0, plus one), then front porch (HTIME bits 15:8 plus one). Hsync is active high when not inverted.
- R4: de_o is high only on active pixels of active lines, never during a sync pulse, so one frame holds exactly width times height enabled pixels, the height being SIZE bits 26:16 plus one.
- R5: Each frame is vsync (VTIME address 2, bits 23:16, plus one lines), back porch (VTIME bits 7:0 plus one), active height, front porch (VTIME bits 15:8 plus one); each line lasts the full line total in pixels.
- R6: With the divide select (CTRL bit 2) clear, one pixel advances per clock; with it set, one pixel advances every CTRL bits 15:8 plus one clocks, and pix_en_o pulses once per pixel.
- R7: Geometry and the frame run bit are written to a pending copy; the running frame keeps its old values and the new ones take effect from the next frame start.
- R8: While the protect bit (CTRL bit 16) is set, the frame-start load is skipped; pending values take effect at the first frame start after protect is cleared.
- R9: Clearing the frame run bit lets the current frame finish and then stops the scan; clearing the immediate run bit forces the outputs inactive within two clocks.
- R10: The interrupt pending flag is set only when both the global enable (IRQCTL address 4, bit 0) and the frame enable (IRQCTL bit 1) are set, at the trigger chosen by IRQCTL bits 3:2: 0 is frame start, on the same clock that vsync asserts; 1 is the start of the vertical front porch, after the last enabled pixel of the frame; other values never trigger.
- R11: irq_o stays set until a write to address 5 with bit 0 set; a write there with bit 0 clear leaves it unchanged.
- R12: CTRL bits 18, 19 and 20 invert hsync_o, vsync_o and de_o respectively, immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_en_o | output | 1 | Pixel-rate enable from the divider |
| irq_o | output | 1 | Sticky frame interrupt |

## Verification
A wrong position counter or region bound shows at the ports within one line as a wrong hsync width, line period or sync-to-enable offset, and within one frame as a wrong enabled-pixel count or frame period. A wrong live/pending copy decision shows only one or two frames later, so the shadow and protect tests count enabled pixels across consecutive frames around each write. Interrupt faults show on the clock of the trigger, where irq_o is sampled against the rise of vsync or the last enabled pixel.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    parameter int PORCH_W = 8;
    parameter int SIZE_W  = 11;
    parameter int DIV_W   = 8;
    localparam int CNT_W  = SIZE_W + 2;

    typedef struct packed {
        logic               run;
        logic [PORCH_W-1:0] hsw;
        logic [PORCH_W-1:0] hbp;
        logic [PORCH_W-1:0] hfp;
        logic [PORCH_W-1:0] vsw;
        logic [PORCH_W-1:0] vbp;
        logic [PORCH_W-1:0] vfp;
        logic [SIZE_W-1:0]  wid;
        logic [SIZE_W-1:0]  hgt;
    } timing_t;
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             evt_fs_i,
    input  logic             evt_fp_i,
    output logic             run_now_o,
    output logic             div_sel_o,
    output logic [DIV_W-1:0] div_m1_o,
    output logic             protect_o,
    output logic [2:0]       inv_o,
    output timing_t          pend_o,
    output logic             irq_o
);
    typedef struct packed {
        logic             run_now;
        logic             div_sel;
        logic [DIV_W-1:0] div_m1;
        logic             protect;
        logic [2:0]       inv;
        timing_t          pend;
        logic             gie;
        logic             fie;
        logic [1:0]       sel;
        logic             irq;
    } reg_t;

    reg_t r_d, r_q;
    logic clr_req;
    logic trig;

    always_comb begin
        r_d     = r_q;
        clr_req = wr_en && (wr_addr == 3'd5) && wr_data[0];
        trig    = r_q.gie && r_q.fie &&
                  (((r_q.sel == 2'd0) && evt_fs_i) || ((r_q.sel == 2'd1) && evt_fp_i));
        if (wr_en) begin
            case (wr_addr)
                3'd0: begin
                    r_d.run_now  = wr_data[0];
                    r_d.pend.run = wr_data[1];
                    r_d.div_sel  = wr_data[2];
                    r_d.div_m1   = wr_data[8 +: DIV_W];
                    r_d.protect  = wr_data[16];
                    r_d.inv      = wr_data[20:18];
                end
                3'd1: begin
                    r_d.pend.hbp = wr_data[0  +: PORCH_W];
                    r_d.pend.hfp = wr_data[8  +: PORCH_W];
                    r_d.pend.hsw = wr_data[16 +: PORCH_W];
                end
                3'd2: begin
                    r_d.pend.vbp = wr_data[0  +: PORCH_W];
                    r_d.pend.vfp = wr_data[8  +: PORCH_W];
                    r_d.pend.vsw = wr_data[16 +: PORCH_W];
                end
                3'd3: begin
                    r_d.pend.wid = wr_data[0  +: SIZE_W];
                    r_d.pend.hgt = wr_data[16 +: SIZE_W];
                end
                3'd4: begin
                    r_d.gie = wr_data[0];
                    r_d.fie = wr_data[1];
                    r_d.sel = wr_data[3:2];
                end
                default: ;
            endcase
        end
        if (clr_req) r_d.irq = 1'b0;
        if (trig)    r_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run_now_o = r_q.run_now;
    assign div_sel_o = r_q.div_sel;
    assign div_m1_o  = r_q.div_m1;
    assign protect_o = r_q.protect;
    assign inv_o     = r_q.inv;
    assign pend_o    = r_q.pend;
    assign irq_o     = r_q.irq;

    a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !(wr_en && wr_addr == 3'd5 && wr_data[0]) |=> irq_o);

    a_r10_irq_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && !(r_q.gie && r_q.fie) |=> !irq_o);
endmodule

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_sel_i,
    input  logic [DIV_W-1:0] div_m1_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = !div_sel_i || (cnt_q >= div_m1_i);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && div_sel_i && div_m1_i != '0 |=> !tick_o || !div_sel_i || div_m1_i == '0);
endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_i,
    input  logic    run_now_i,
    input  logic    protect_i,
    input  timing_t pend_i,
    output logic    hs_o,
    output logic    vs_o,
    output logic    de_o,
    output logic    evt_fs_o,
    output logic    evt_fp_o
);
    localparam logic [CNT_W-1:0] ONE = 1;

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] h;
        logic [CNT_W-1:0] v;
        timing_t          live;
    } scan_t;

    scan_t s_d, s_q;
    timing_t nxt_live;
    logic [CNT_W-1:0] h_sync, h_lo, h_hi, h_tot;
    logic [CNT_W-1:0] v_sync, v_lo, v_hi, v_tot;
    logic end_line, end_frame, boundary;

    always_comb begin
        h_sync = CNT_W'(s_q.live.hsw) + ONE;
        h_lo   = h_sync + CNT_W'(s_q.live.hbp) + ONE;
        h_hi   = h_lo + CNT_W'(s_q.live.wid) + ONE;
        h_tot  = h_hi + CNT_W'(s_q.live.hfp) + ONE;
        v_sync = CNT_W'(s_q.live.vsw) + ONE;
        v_lo   = v_sync + CNT_W'(s_q.live.vbp) + ONE;
        v_hi   = v_lo + CNT_W'(s_q.live.hgt) + ONE;
        v_tot  = v_hi + CNT_W'(s_q.live.vfp) + ONE;

        end_line  = (s_q.h == h_tot - ONE);
        end_frame = end_line && (s_q.v == v_tot - ONE);
        boundary  = tick_i && (!s_q.running || end_frame);
        nxt_live  = protect_i ? s_q.live : pend_i;

        s_d      = s_q;
        evt_fs_o = 1'b0;
        evt_fp_o = 1'b0;
        if (!run_now_i) begin
            s_d.running = 1'b0;
            s_d.h       = '0;
            s_d.v       = '0;
        end else if (boundary) begin
            s_d.live    = nxt_live;
            s_d.running = nxt_live.run;
            s_d.h       = '0;
            s_d.v       = '0;
            evt_fs_o    = nxt_live.run;
        end else if (tick_i && s_q.running) begin
            if (end_line) begin
                s_d.h    = '0;
                s_d.v    = s_q.v + ONE;
                evt_fp_o = (s_q.v + ONE == v_hi);
            end else begin
                s_d.h = s_q.h + ONE;
            end
        end

        hs_o = s_q.running && (s_q.h < h_sync);
        vs_o = s_q.running && (s_q.v < v_sync);
        de_o = s_q.running && (s_q.h >= h_lo) && (s_q.h < h_hi) &&
               (s_q.v >= v_lo) && (s_q.v < v_hi);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> !hs_o && !vs_o);

    a_r9_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
        !run_now_i |=> !s_q.running);

    a_r8_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        protect_i |=> $stable(s_q.live));

    a_r3_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.running |-> (s_q.h < h_tot) && (s_q.v < v_tot));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic        hsync_o,
    output logic        vsync_o,
    output logic        de_o,
    output logic        pix_en_o,
    output logic        irq_o
);
    logic             run_now, div_sel, protect, tick;
    logic [DIV_W-1:0] div_m1;
    logic [2:0]       inv;
    timing_t          pend;
    logic             hs_raw, vs_raw, de_raw, evt_fs, evt_fp;

    lcdt_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .evt_fs_i(evt_fs), .evt_fp_i(evt_fp), .run_now_o(run_now), .div_sel_o(div_sel),
        .div_m1_o(div_m1), .protect_o(protect), .inv_o(inv), .pend_o(pend), .irq_o(irq_o)
    );

    lcdt_clkdiv i_div (
        .clk(clk), .rst_n(rst_n), .div_sel_i(div_sel), .div_m1_i(div_m1), .tick_o(tick)
    );

    lcdt_scan i_scan (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_now_i(run_now), .protect_i(protect),
        .pend_i(pend), .hs_o(hs_raw), .vs_o(vs_raw), .de_o(de_raw),
        .evt_fs_o(evt_fs), .evt_fp_o(evt_fp)
    );

    assign hsync_o  = hs_raw ^ inv[0];
    assign vsync_o  = vs_raw ^ inv[1];
    assign de_o     = de_raw ^ inv[2];
    assign pix_en_o = tick;
endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
    localparam time PERIOD = 10ns;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic        hsync_o, vsync_o, de_o, pix_en_o, irq_o;
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    // geometry: line 2+3+4+2 = 11 pixels, frame 1+2+3+1 = 7 lines
    localparam logic [31:0] HT = {8'd0, 8'd1, 8'd1, 8'd2};
    localparam logic [31:0] VT = {8'd0, 8'd0, 8'd0, 8'd1};
    localparam logic [31:0] SZ4 = {5'd0, 11'd2, 5'd0, 11'd3};
    localparam logic [31:0] SZ6 = {5'd0, 11'd2, 5'd0, 11'd5};
    localparam logic [31:0] RUN = 32'h3;

    lcd_timing_gen i_lcd_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_en_o(pix_en_o), .irq_o(irq_o)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %0d exp %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int s);
        case (s)
            0: return hsync_o;
            1: return vsync_o;
            2: return de_o;
            default: return ~hsync_o;
        endcase
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_rise(input int s, output int t);
        logic p;
        bit   hit;
        p = sig(s); t = -1; hit = 0;
        for (int n = 0; n < 3000 && !hit; n++) begin
            @(negedge clk);
            if (sig(s) && !p) begin t = cyc; hit = 1; end
            p = sig(s);
        end
        if (!hit) chk(0, "timeout", 0, 1);
    endtask

    task automatic high_len(input int s, output int n);
        int t;
        wait_rise(s, t);
        n = 0;
        for (int k = 0; k < 3000 && sig(s); k++) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_to_vs(output int n);
        logic p;
        bit   hit;
        n = 0; p = vsync_o; hit = 0;
        for (int k = 0; k < 3000 && !hit; k++) begin
            @(negedge clk);
            if (vsync_o && !p) hit = 1;
            else n += int'(de_o);
            p = vsync_o;
        end
        if (!hit) chk(0, "timeout", 0, 1);
    endtask

    task automatic t_reset();
        chk(!hsync_o && !vsync_o && !de_o && !irq_o, "R1 reset idle",
            {hsync_o, vsync_o, de_o, irq_o}, 0);
    endtask

    task automatic t_enables();
        int act;
        wr(3'd1, HT); wr(3'd2, VT); wr(3'd3, SZ4);
        wr(3'd0, 32'h1);
        act = 0;
        repeat (200) begin @(negedge clk); act += int'(hsync_o | vsync_o | de_o); end
        chk(act == 0, "R2 immediate run only", act, 0);
        wr(3'd0, 32'h2);
        act = 0;
        repeat (200) begin @(negedge clk); act += int'(hsync_o | vsync_o | de_o); end
        chk(act == 0, "R2 frame run only", act, 0);
        wr(3'd0, RUN);
    endtask

    task automatic t_horiz();
        int n, t1, t2, th, td;
        logic ph, pd;
        bit hit;
        high_len(0, n);
        chk(n == 2, "R3 hsync width", n, 2);
        wait_rise(0, t1); wait_rise(0, t2);
        chk(t2 - t1 == 11, "R3 line period", t2 - t1, 11);
        wait_rise(1, t1);
        ph = hsync_o; pd = de_o; th = 0; td = 0; hit = 0;
        for (int k = 0; k < 3000 && !hit; k++) begin
            @(negedge clk);
            if (hsync_o && !ph) th = cyc;
            if (de_o && !pd) begin td = cyc; hit = 1; end
            ph = hsync_o; pd = de_o;
        end
        chk(td - th == 5, "R3 sync to active offset", td - th, 5);
        high_len(2, n);
        chk(n == 4, "R4 active width", n, 4);
    endtask

    task automatic t_frame();
        int n, t1, t2;
        high_len(1, n);
        chk(n == 11, "R5 vsync width", n, 11);
        wait_rise(1, t1); wait_rise(1, t2);
        chk(t2 - t1 == 77, "R5 frame period", t2 - t1, 77);
        count_to_vs(n);
        chk(n == 12, "R4 enabled pixels per frame", n, 12);
    endtask

    task automatic t_shadow();
        int t, n;
        wait_rise(1, t);
        wr(3'd3, SZ6);
        count_to_vs(n);
        chk(n == 12, "R7 current frame keeps old size", n, 12);
        count_to_vs(n);
        chk(n == 18, "R7 next frame uses new size", n, 18);
    endtask

    task automatic t_protect();
        int t, n;
        wait_rise(1, t);
        wr(3'd0, RUN | 32'h1_0000);
        wr(3'd3, SZ4);
        count_to_vs(n);
        chk(n == 18, "R8 frame before protected start", n, 18);
        wr(3'd0, RUN);
        count_to_vs(n);
        chk(n == 18, "R8 protected start skipped load", n, 18);
        count_to_vs(n);
        chk(n == 12, "R8 load after protect cleared", n, 12);
    endtask

    task automatic t_irq();
        int t, n;
        bit hit;
        wr(3'd4, 32'h2);
        wr(3'd5, 32'h1);
        wait_rise(1, t); wait_rise(1, t);
        chk(!irq_o, "R10 no set without global enable", irq_o, 0);
        wr(3'd4, 32'h3);
        wait_rise(1, t);
        chk(irq_o, "R10 set with vsync rise", irq_o, 1);
        wr(3'd5, 32'h0);
        chk(irq_o, "R11 write of zero keeps pending", irq_o, 1);
        wr(3'd5, 32'h1);
        chk(!irq_o, "R11 write of one clears", irq_o, 0);
        wr(3'd4, 32'h7);
        wait_rise(1, t);
        wr(3'd5, 32'h1);
        n = 0; hit = 0;
        for (int k = 0; k < 3000 && !hit; k++) begin
            @(negedge clk);
            if (irq_o) hit = 1;
            else n += int'(de_o);
        end
        chk(hit && n == 12 && !vsync_o, "R10 front porch trigger", n, 12);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h1);
    endtask

    task automatic t_div();
        int n, t1, t2, p;
        wr(3'd0, 32'h2);
        @(negedge clk);
        chk(!hsync_o && !vsync_o && !de_o, "R9 immediate stop",
            {hsync_o, vsync_o, de_o}, 0);
        wr(3'd0, RUN | 32'h0000_0204);
        wait_rise(0, t1); wait_rise(0, t2);
        chk(t2 - t1 == 33, "R6 divided line period", t2 - t1, 33);
        p = 0;
        repeat (33) begin @(negedge clk); p += int'(pix_en_o); end
        chk(p == 11, "R6 pixel enables per line", p, 11);
        high_len(0, n);
        chk(n == 6, "R6 divided hsync width", n, 6);
        wr(3'd0, 32'h2);
        wr(3'd0, RUN);
    endtask

    task automatic t_stop();
        int t, n, r;
        logic p;
        wait_rise(1, t);
        wr(3'd0, 32'h1);
        n = 0; r = 0; p = vsync_o;
        repeat (300) begin
            @(negedge clk);
            n += int'(de_o);
            if (vsync_o && !p) r++;
            p = vsync_o;
        end
        chk(n == 12, "R9 current frame finishes", n, 12);
        chk(r == 0, "R9 no further frame", r, 0);
    endtask

    task automatic t_invert();
        int n;
        wr(3'd0, 32'h1C_0000);
        @(negedge clk);
        chk(hsync_o && vsync_o && de_o, "R12 idle levels inverted",
            {hsync_o, vsync_o, de_o}, 7);
        wr(3'd0, RUN | 32'h4_0000);
        high_len(3, n);
        chk(n == 2, "R12 inverted hsync low width", n, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_horiz();
        t_frame();
        t_shadow();
        t_protect();
        t_irq();
        t_div();
        t_stop();
        t_invert();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule